// File: doc/BRIEF.md
# UART Modem Control and Status Unit

This block is the modem-signal section of a 16550-style asynchronous serial controller. It keeps a six-bit modem control register and presents an eight-bit modem status view on a small CPU register bus with one address bit. It drives the four active-low modem outputs from the control bits, brings in the four active-low modem inputs through a synchronizer, and latches a change flag per input. A modem-status interrupt request is raised from the flags under the interrupt enable that the surrounding controller supplies. Reading the status clears the flags.

One control bit turns on a diagnostic loopback. The external serial output is then held high and the external serial input is ignored. The transmit serial stream is sent to the receive input. The four external modem inputs are ignored, the control bits take their place as the status sources, and the external modem output pins are parked at their inactive high level. Two control bits together choose one of three flow-control modes, and the decoded enables go to the transmitter and receiver.

Top module: `uart_modem_ctl`

## Requirements
- R1: After reset the control register is 0, all four modem output pins and `sout` are high, both flow enables are 0, `modem_irq` is 0, and a status read with all modem inputs high returns 0x00.
- R2: A write with `reg_addr`=0 stores `wr_data[5:0]` in the control register. Bit 0 is DTR, bit 1 is RTS, bit 2 is OUT1, bit 3 is OUT2, bit 4 is loopback and bit 5 is auto-flow enable. A read with `reg_addr`=0 returns the register with bits 7:6 zero, on the rising edge where `rd_en` is sampled.
- R3: Outside loopback, each modem output pin is the inverse of its control bit, registered one edge after the control register changes.
- R4: A read with `reg_addr`=1 returns the status byte. Bits 7..4 are the active-high levels of DCD, RI, DSR and CTS (bit 7 DCD, bit 6 RI, bit 5 DSR, bit 4 CTS). A pin level reaches them two rising edges after the pin changes.
- R5: Bit 0 (CTS change), bit 1 (DSR change) and bit 3 (DCD change) set on any change of their level. Bit 2 sets only when RI goes from active to inactive. A flag sets on the third rising edge after its pin changes, and it stays set until a status read.
- R6: A status read clears all four change flags. A change that sets a flag on the same edge as the read keeps that flag set, and the next read reports it.
- R7: `modem_irq` is high exactly when `msi_en` is 1 and at least one contributing flag is set. It falls right after the clearing read.
- R8: While auto-flow enable is 1, the CTS change flag still sets but does not contribute to `modem_irq`.
- R9: In loopback `sout` is registered high, `rx_bit` is `tx_bit` delayed one edge, and `sin` has no effect.
- R10: In loopback all modem output pins are registered high and the external modem inputs have no effect. The status sources become RTS for CTS, DTR for DSR, OUT1 for RI and OUT2 for DCD, and the change flags follow them one edge after the control write.
- R11: `auto_cts_en` equals control bit 5, and `auto_rts_en` equals bit 5 AND bit 1. With bit 5 at 0 both are 0, whatever bit 1 holds.
- R12: Outside loopback `sout` is `tx_bit` delayed one edge and `rx_bit` is `sin` delayed one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 1 | 0 selects control, 1 selects status |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wr_data | input | 6 | Control write data |
| rd_data | output | 8 | Registered read data |
| msi_en | input | 1 | Modem-status interrupt enable |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| dcd_n | input | 1 | Carrier-detect pin, active low |
| ri_n | input | 1 | Ring-indicator pin, active low |
| dtr_n | output | 1 | Terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| out1_n | output | 1 | General output 1, active low |
| out2_n | output | 1 | General output 2, active low |
| tx_bit | input | 1 | Serial stream from the transmit shifter |
| rx_bit | output | 1 | Serial stream to the receive shifter |
| sin | input | 1 | External serial input |
| sout | output | 1 | External serial output |
| auto_rts_en | output | 1 | Decoded automatic RTS enable |
| auto_cts_en | output | 1 | Decoded automatic CTS enable |
| modem_irq | output | 1 | Modem-status interrupt request |

## Verification
The latency from each stimulus is fixed. Pin levels show in the status two edges after a pin change and flags on the third. Output pins and the serial paths follow one edge after their source. Flow enables and loopback status sources follow the control write edge, and flags in loopback set one edge after it. The bench drives on falling edges and waits exactly these counts before it samples, and in a few places it also checks one cycle early that a result has not yet appeared. Read data goes through a scoreboard queue and is compared on the falling edge after the sampling rising edge. One read is placed on the very edge where a flag sets, to show that the flag is not lost.

// File: rtl/uart_modem_pkg.sv
package uart_modem_pkg;
  localparam int MCR_W    = 6;
  localparam int REG_W    = 8;
  localparam int N_LINES  = 4;
  // control bit positions
  localparam int C_DTR    = 0;
  localparam int C_RTS    = 1;
  localparam int C_OUT1   = 2;
  localparam int C_OUT2   = 3;
  localparam int C_LOOP   = 4;
  localparam int C_AFE    = 5;
  // line index, equals flag bit and level bit minus N_LINES
  localparam int L_CTS    = 0;
  localparam int L_DSR    = 1;
  localparam int L_RI     = 2;
  localparam int L_DCD    = 3;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;
endpackage

// File: rtl/uart_mdm_sync.sv
module uart_mdm_sync #(
  parameter int WIDTH   = 4,
  parameter int STAGES  = 2,
  parameter logic RST_V = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= {WIDTH{RST_V}};
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_mdm_edge.sv
module uart_mdm_edge #(
  parameter bit FALL_ONLY = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic clr,
  output logic chg,
  output logic flag
);
  logic prev_q;

  generate
    if (FALL_ONLY) begin : g_fall
      assign chg = prev_q & ~level;
    end else begin : g_any
      assign chg = prev_q ^ level;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      flag   <= 1'b0;
    end else begin
      prev_q <= level;
      if (chg)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_mdm_flow.sv
module uart_mdm_flow (
  input  logic afe,
  input  logic rts,
  output logic auto_rts,
  output logic auto_cts
);
  always_comb begin
    auto_cts = afe;
    auto_rts = afe & rts;
  end
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
  import uart_modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [MCR_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             msi_en,
  input  logic             cts_n,
  input  logic             dsr_n,
  input  logic             dcd_n,
  input  logic             ri_n,
  output logic             dtr_n,
  output logic             rts_n,
  output logic             out1_n,
  output logic             out2_n,
  input  logic             tx_bit,
  output logic             rx_bit,
  input  logic             sin,
  output logic             sout,
  output logic             auto_rts_en,
  output logic             auto_cts_en,
  output logic             modem_irq
);
  localparam int PAD_W = REG_W - MCR_W;

  logic [MCR_W-1:0]   mcr_q;
  logic [N_LINES-1:0] pin_n, sync_n, ext_lvl, lb_lvl, lvl;
  logic [N_LINES-1:0] chg_vec, flags_q;
  logic               loop_on, stat_rd;

  assign loop_on = mcr_q[C_LOOP];
  assign stat_rd = rd_en && (reg_addr == ADDR_STAT);

  // control register
  always_ff @(posedge clk) begin
    if (rst) mcr_q <= '0;
    else if (wr_en && reg_addr == ADDR_CTRL) mcr_q <= wr_data;
  end

  // input synchronizer, pins idle high
  always_comb begin
    pin_n[L_CTS] = cts_n;
    pin_n[L_DSR] = dsr_n;
    pin_n[L_RI]  = ri_n;
    pin_n[L_DCD] = dcd_n;
  end

  uart_mdm_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES), .RST_V(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_n),
    .q   (sync_n)
  );

  always_comb begin
    ext_lvl        = ~sync_n;
    lb_lvl[L_CTS]  = mcr_q[C_RTS];
    lb_lvl[L_DSR]  = mcr_q[C_DTR];
    lb_lvl[L_RI]   = mcr_q[C_OUT1];
    lb_lvl[L_DCD]  = mcr_q[C_OUT2];
    lvl            = loop_on ? lb_lvl : ext_lvl;
  end

  // per-line change detection
  genvar i;
  generate
    for (i = 0; i < N_LINES; i++) begin : g_line
      uart_mdm_edge #(.FALL_ONLY(i == L_RI)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (lvl[i]),
        .clr   (stat_rd),
        .chg   (chg_vec[i]),
        .flag  (flags_q[i])
      );
    end
  endgenerate

  // read data
  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) begin
      if (reg_addr == ADDR_STAT) rd_data <= {lvl[L_DCD], lvl[L_RI], lvl[L_DSR], lvl[L_CTS], flags_q};
      else                       rd_data <= {{PAD_W{1'b0}}, mcr_q};
    end
  end

  // output pins and serial paths
  always_ff @(posedge clk) begin
    if (rst) begin
      dtr_n  <= 1'b1;
      rts_n  <= 1'b1;
      out1_n <= 1'b1;
      out2_n <= 1'b1;
      sout   <= 1'b1;
      rx_bit <= 1'b1;
    end else begin
      dtr_n  <= loop_on | ~mcr_q[C_DTR];
      rts_n  <= loop_on | ~mcr_q[C_RTS];
      out1_n <= loop_on | ~mcr_q[C_OUT1];
      out2_n <= loop_on | ~mcr_q[C_OUT2];
      sout   <= loop_on | tx_bit;
      rx_bit <= loop_on ? tx_bit : sin;
    end
  end

  uart_mdm_flow u_flow (
    .afe      (mcr_q[C_AFE]),
    .rts      (mcr_q[C_RTS]),
    .auto_rts (auto_rts_en),
    .auto_cts (auto_cts_en)
  );

  // interrupt request
  always_comb begin
    modem_irq = msi_en & ((flags_q[L_CTS] & ~mcr_q[C_AFE]) | flags_q[L_DSR] |
                          flags_q[L_RI] | flags_q[L_DCD]);
  end
endmodule

// File: rtl/uart_modem_ctl_chk.sv
module uart_modem_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic [5:0] mcr_q,
  input logic [3:0] flags_q,
  input logic [3:0] chg_vec,
  input logic       stat_rd,
  input logic       msi_en,
  input logic       sout,
  input logic       dtr_n,
  input logic       rts_n,
  input logic       out1_n,
  input logic       out2_n,
  input logic       auto_rts_en,
  input logic       auto_cts_en,
  input logic       modem_irq
);
  assert_loop_sout_R9: assert property (@(posedge clk) disable iff (rst)
    mcr_q[4] |=> sout);

  assert_loop_pins_R10: assert property (@(posedge clk) disable iff (rst)
    mcr_q[4] |=> (dtr_n && rts_n && out1_n && out2_n));

  assert_read_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && chg_vec == 4'b0) |=> (flags_q == 4'b0));

  assert_flag_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !stat_rd |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (rst)
    !msi_en |-> !modem_irq);

  assert_afe_cts_R8: assert property (@(posedge clk) disable iff (rst)
    (mcr_q[5] && flags_q == 4'b0001) |-> !modem_irq);

  assert_flow_R11: assert property (@(posedge clk) disable iff (rst)
    auto_rts_en |-> auto_cts_en);
endmodule

bind uart_modem_ctl uart_modem_ctl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .mcr_q       (mcr_q),
  .flags_q     (flags_q),
  .chg_vec     (chg_vec),
  .stat_rd     (stat_rd),
  .msi_en      (msi_en),
  .sout        (sout),
  .dtr_n       (dtr_n),
  .rts_n       (rts_n),
  .out1_n      (out1_n),
  .out2_n      (out2_n),
  .auto_rts_en (auto_rts_en),
  .auto_cts_en (auto_cts_en),
  .modem_irq   (modem_irq)
);

// File: tb/tb_uart_modem_ctl.sv
module tb_uart_modem_ctl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0] wr_data = '0;
  logic [7:0] rd_data;
  logic msi_en = 1'b0;
  logic cts_n = 1'b1, dsr_n = 1'b1, dcd_n = 1'b1, ri_n = 1'b1;
  logic dtr_n, rts_n, out1_n, out2_n;
  logic tx_bit = 1'b1, sin = 1'b1;
  logic rx_bit, sout, auto_rts_en, auto_cts_en, modem_irq;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  uart_modem_ctl dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .msi_en(msi_en),
    .cts_n(cts_n), .dsr_n(dsr_n), .dcd_n(dcd_n), .ri_n(ri_n),
    .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n),
    .tx_bit(tx_bit), .rx_bit(rx_bit), .sin(sin), .sout(sout),
    .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en), .modem_irq(modem_irq)
  );

  // scoreboard
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_pend = 1'b0;

  always @(posedge clk) rd_pend <= rd_en;

  always @(negedge clk) begin
    if (rd_pend) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: read with no expected item, actual=%02h expected=none", rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s: actual=%02h expected=%02h", t, rd_data, e);
        end
      end
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [5:0] v);
    reg_addr = 1'b0; wr_data = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_reg(input logic a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    reg_addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic logic [7:0] pins();
    return {4'b0, out2_n, out1_n, rts_n, dtr_n};
  endfunction

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog: actual=timeout expected=finish");
          $display("Result: errors=%0d of %0d checks", errors, checks);
          $finish;
        end
      end
    join_none

    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    chk(pins(), 8'h0F, "R1 pins");
    chk({7'b0, sout}, 8'h01, "R1 sout");
    chk({6'b0, auto_rts_en, auto_cts_en}, 8'h00, "R1 flow");
    chk({7'b0, modem_irq}, 8'h00, "R1 irq");
    cyc(3);
    rd_reg(1'b1, 8'h00, "R1 status");
    rd_reg(1'b0, 8'h00, "R1 control");

    // R2 / R3 control write and pins
    wr_ctrl(6'h0B);
    rd_reg(1'b0, 8'h0B, "R2 control readback");
    chk(pins(), 8'h04, "R3 pins");
    chk({6'b0, auto_rts_en, auto_cts_en}, 8'h00, "R11 afe off");

    // R12 normal serial
    tx_bit = 1'b0; sin = 1'b1;
    cyc(1);
    chk({6'b0, sout, rx_bit}, 8'h01, "R12 serial a");
    tx_bit = 1'b1; sin = 1'b0;
    cyc(1);
    chk({6'b0, sout, rx_bit}, 8'h02, "R12 serial b");

    // R5 / R7 CTS change timing
    msi_en = 1'b1;
    cts_n = 1'b0;
    cyc(2);
    chk({7'b0, modem_irq}, 8'h00, "R5 flag not yet set");
    cyc(1);
    chk({7'b0, modem_irq}, 8'h01, "R7 irq on cts change");
    rd_reg(1'b1, 8'h11, "R4 R5 cts status");
    chk({7'b0, modem_irq}, 8'h00, "R7 irq cleared by read");
    rd_reg(1'b1, 8'h10, "R6 flags cleared");

    // DSR
    dsr_n = 1'b0;
    cyc(4);
    rd_reg(1'b1, 8'h32, "R5 dsr change");
    // RI: leading edge gives no flag, trailing edge does
    ri_n = 1'b0;
    cyc(4);
    chk({7'b0, modem_irq}, 8'h00, "R5 ri leading edge no irq");
    rd_reg(1'b1, 8'h70, "R5 ri leading edge");
    ri_n = 1'b1;
    cyc(4);
    chk({7'b0, modem_irq}, 8'h01, "R7 ri trailing irq");
    rd_reg(1'b1, 8'h34, "R5 ri trailing edge");
    // DCD
    dcd_n = 1'b0;
    cyc(4);
    rd_reg(1'b1, 8'hB8, "R5 dcd change");
    rd_reg(1'b1, 8'hB0, "R6 after dcd");

    // R7 enable gating
    msi_en = 1'b0;
    dsr_n = 1'b1;
    cyc(4);
    chk({7'b0, modem_irq}, 8'h00, "R7 irq masked");
    msi_en = 1'b1;
    cyc(1);
    chk({7'b0, modem_irq}, 8'h01, "R7 irq unmasked");
    rd_reg(1'b1, 8'h92, "R5 dsr release");
    rd_reg(1'b1, 8'h90, "R6 clear");

    // R11 flow decode
    wr_ctrl(6'h22);
    chk({6'b0, auto_rts_en, auto_cts_en}, 8'h03, "R11 both");
    wr_ctrl(6'h20);
    chk({6'b0, auto_rts_en, auto_cts_en}, 8'h01, "R11 cts only");
    wr_ctrl(6'h02);
    chk({6'b0, auto_rts_en, auto_cts_en}, 8'h00, "R11 afe clear rts set");
    // R8 cts change with auto-flow
    wr_ctrl(6'h20);
    cts_n = 1'b1;
    cyc(4);
    chk({7'b0, modem_irq}, 8'h00, "R8 cts change suppressed");
    rd_reg(1'b1, 8'h81, "R8 cts flag still set");
    rd_reg(1'b1, 8'h80, "R6 clear after R8");

    // R6 change on the same edge as a read
    wr_ctrl(6'h00);
    cts_n = 1'b0;
    cyc(2);
    rd_reg(1'b1, 8'h90, "R6 coincident read");
    rd_reg(1'b1, 8'h91, "R6 coincident flag kept");
    rd_reg(1'b1, 8'h90, "R6 cleared later");

    // R9 / R10 loopback
    wr_ctrl(6'h10);
    cyc(2);
    rd_reg(1'b1, 8'h09, "R10 enter loopback flags");
    rd_reg(1'b1, 8'h00, "R10 loopback levels");
    tx_bit = 1'b0; sin = 1'b1;
    cyc(1);
    chk({6'b0, sout, rx_bit}, 8'h02, "R9 loop tx0");
    tx_bit = 1'b1; sin = 1'b0;
    cyc(1);
    chk({6'b0, sout, rx_bit}, 8'h03, "R9 loop tx1");
    wr_ctrl(6'h1F);
    cyc(1);
    chk(pins(), 8'h0F, "R10 pins parked");
    chk({7'b0, modem_irq}, 8'h01, "R10 loop irq");
    rd_reg(1'b1, 8'hFB, "R10 status from control");
    rd_reg(1'b1, 8'hF0, "R10 cleared");
    cts_n = 1'b1; dsr_n = 1'b0; dcd_n = 1'b1; ri_n = 1'b0;
    cyc(5);
    rd_reg(1'b1, 8'hF0, "R10 external inputs ignored");
    wr_ctrl(6'h1B);
    cyc(1);
    rd_reg(1'b1, 8'hB4, "R10 out1 trailing ri");

    // leave loopback
    cts_n = 1'b1; dsr_n = 1'b1; dcd_n = 1'b1; ri_n = 1'b1;
    cyc(4);
    wr_ctrl(6'h00);
    cyc(1);
    rd_reg(1'b1, 8'h0B, "R10 exit flags");
    tx_bit = 1'b0;
    cyc(1);
    chk({7'b0, sout}, 8'h00, "R12 sout after loopback");
    chk(pins(), 8'h0F, "R3 pins idle");

    cyc(2);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule